// File: doc/BRIEF.md
# Serial ADC Readout Host Controller

This block runs a single acquisition from a successive-approximation ADC with serial output. The result is read after the conversion has finished. A request pulse starts the sequence. The controller pulls chip select low and waits a programmable setup interval. It then issues an active-low start pulse whose edges coincide with falling edges of the conversion clock, and waits for the converter to signal end of conversion. After that it generates a gated serial clock and shifts the result in, most significant bit first.

The converter places the first bit on its data line before any serial clock edge and moves to the next bit on each serial clock falling edge. The controller therefore samples at the instant it raises the serial clock. Without this, the leading bit would be lost. The assembled word is presented with a one-cycle valid strobe once a hold interval has passed and chip select has been released.

If end of conversion never arrives, a timeout counted in conversion clock periods aborts the transfer and releases chip select. It also raises a one-cycle error strobe. Both the conversion clock and the serial clock are derived from the system clock by half-period divider parameters. These parameters are chosen so that the conversion clock stays at or below 1.7 MHz and the serial clock at or below 5 MHz.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, chip select and start are high (inactive), the serial clock is low, busy, valid and error are low, and the data word is zero.
- R2: A request is accepted only while idle; acceptance drives chip select low and busy high on the next clock edge, and a request raised while busy starts no further acquisition.
- R3: The start pulse falls no earlier than CS_SETUP system cycles after chip select falls. It changes level only on a system edge where the conversion clock falls, lasts exactly one conversion clock period, and is only low while chip select is low.
- R4: The serial clock stays low until end of conversion (active low) has been seen low with chip select low; on a timeout no serial clock pulse is produced.
- R5: A readout consists of exactly WORD_W serial clock pulses, starting from low, with each low and high phase lasting SCLK_HALF system cycles; the serial clock is only high while chip select is low.
- R6: The data input is sampled on the system edge that raises the serial clock, and the first bit sampled becomes bit WORD_W-1 of the result, so that the word equals the bits in arrival order.
- R7: Chip select rises no earlier than CS_HOLD system cycles after the last serial clock falling edge.
- R8: Valid is high for exactly one system cycle, on the same edge that chip select rises after a good readout, and the data output holds the received word from then on.
- R9: If end of conversion is not seen low within EOC_TIMEOUT conversion clock falling edges after the start pulse ends, chip select rises on the EOC_TIMEOUT-th such edge, error pulses for one cycle, valid stays low and the data output keeps its previous value.
- R10: Busy is high from the accepting edge until the edge on which chip select is released, and falls on that same edge.
- R11: The conversion clock runs continuously with low and high phases of CONV_HALF system cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Acquisition request |
| busy_o | output | 1 | Acquisition in progress |
| data_o | output | WORD_W | Last received conversion word |
| valid_o | output | 1 | One-cycle strobe: new word on data_o |
| err_o | output | 1 | One-cycle strobe: end-of-conversion timeout |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_start_n_o | output | 1 | Conversion start, active low |
| adc_cclk_o | output | 1 | Conversion clock to the converter |
| adc_sclk_o | output | 1 | Serial readout clock |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_eoc_n_i | input | 1 | End of conversion, active low |

## Verification
The bench builds the block with CONV_HALF=2, SCLK_HALF=2, CS_SETUP=5, CS_HOLD=3 and EOC_TIMEOUT=6. This shortens an acquisition to roughly a hundred cycles, so many random words and conversion lengths fit in a short run. With these values every phase length, the setup and hold gaps, and the exact edge of a timeout abort can be counted in cycles. A converter model that drives the first bit before any serial clock edge and advances only on falling edges exposes a wrong sampling edge as a shifted word. Directed all-zero, all-one and alternating words, a converter that never finishes, and a request repeated while busy cover the corner cases.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ALIGN,
        ST_PULSE,
        ST_WAIT,
        ST_READ,
        ST_HOLD
    } host_state_e;

endpackage

// File: rtl/adc_host_cclk_gen.sv
module adc_host_cclk_gen #(
    parameter int unsigned HALF = 30
) (
    input  logic clk,
    input  logic rst_n,
    output logic cclk_o,
    output logic fall_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d   = cg_q;
        fall_o = 1'b0;
        if (cg_q.cnt == CW'(HALF - 1)) begin
            cg_d.cnt = '0;
            cg_d.lvl = ~cg_q.lvl;
            fall_o   = cg_q.lvl;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cg_q <= '0;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign cclk_o = cg_q.lvl;

endmodule

// File: rtl/adc_host_sclk_gen.sv
module adc_host_sclk_gen #(
    parameter int unsigned HALF  = 10,
    parameter int unsigned NBITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic sclk_o,
    output logic sample_o,
    output logic done_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BW = $clog2(NBITS + 1);

    typedef struct packed {
        logic          active;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bits;
    } sg_t;

    sg_t sg_d, sg_q;

    always_comb begin
        sg_d     = sg_q;
        sample_o = 1'b0;
        done_o   = 1'b0;
        if (start_i) begin
            sg_d.active = 1'b1;
            sg_d.lvl    = 1'b0;
            sg_d.cnt    = '0;
            sg_d.bits   = '0;
        end else if (sg_q.active) begin
            if (sg_q.cnt == CW'(HALF - 1)) begin
                sg_d.cnt = '0;
                sg_d.lvl = ~sg_q.lvl;
                if (!sg_q.lvl) begin
                    // rising edge now: data line still holds the current bit
                    sample_o = 1'b1;
                end else begin
                    sg_d.bits = sg_q.bits + 1'b1;
                    if (sg_q.bits == BW'(NBITS - 1)) begin
                        sg_d.active = 1'b0;
                        done_o      = 1'b1;
                    end
                end
            end else begin
                sg_d.cnt = sg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    assign sclk_o = sg_q.lvl;

endmodule

// File: rtl/adc_host_shift.sv
module adc_host_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         sample_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clear_i) begin
            word_d = '0;
        end else if (sample_i) begin
            word_d = {word_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned CONV_HALF   = 30,
    parameter int unsigned SCLK_HALF   = 10,
    parameter int unsigned CS_SETUP    = 16,
    parameter int unsigned CS_HOLD     = 4,
    parameter int unsigned EOC_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              busy_o,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              adc_cs_n_o,
    output logic              adc_start_n_o,
    output logic              adc_cclk_o,
    output logic              adc_sclk_o,
    input  logic              adc_dout_i,
    input  logic              adc_eoc_n_i
);
    localparam int unsigned GAP_MAX = (CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD;
    localparam int unsigned SW      = $clog2(GAP_MAX + 1);
    localparam int unsigned TW      = $clog2(EOC_TIMEOUT + 1);

    typedef struct packed {
        host_state_e       state;
        logic              cs_n;
        logic              start_n;
        logic [SW-1:0]     cnt;
        logic [TW-1:0]     tmo;
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] data;
        logic              eoc_s1;
        logic              eoc_s2;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              cclk_fall;
    logic              sclk_start;
    logic              sclk_sample;
    logic              sclk_done;
    logic              sh_clear;
    logic [WORD_W-1:0] sh_word;

    adc_host_cclk_gen #(.HALF(CONV_HALF)) u_cclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .cclk_o (adc_cclk_o),
        .fall_o (cclk_fall)
    );

    adc_host_sclk_gen #(.HALF(SCLK_HALF), .NBITS(WORD_W)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sclk_start),
        .sclk_o   (adc_sclk_o),
        .sample_o (sclk_sample),
        .done_o   (sclk_done)
    );

    adc_host_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (sh_clear),
        .sample_i (sclk_sample),
        .bit_i    (adc_dout_i),
        .word_o   (sh_word)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.valid  = 1'b0;
        ctl_d.err    = 1'b0;
        ctl_d.eoc_s1 = adc_eoc_n_i;
        ctl_d.eoc_s2 = ctl_q.eoc_s1;
        sclk_start   = 1'b0;
        sh_clear     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_SETUP;
                    sh_clear    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (ctl_q.cnt >= SW'(CS_SETUP - 1)) begin
                    ctl_d.state = ST_ALIGN;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_ALIGN: begin
                if (cclk_fall) begin
                    ctl_d.start_n = 1'b0;
                    ctl_d.state   = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (cclk_fall) begin
                    ctl_d.start_n = 1'b1;
                    ctl_d.tmo     = '0;
                    ctl_d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!ctl_q.eoc_s2) begin
                    sclk_start  = 1'b1;
                    ctl_d.state = ST_READ;
                end else if (cclk_fall) begin
                    if (ctl_q.tmo == TW'(EOC_TIMEOUT - 1)) begin
                        ctl_d.cs_n  = 1'b1;
                        ctl_d.err   = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.tmo = ctl_q.tmo + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (sclk_done) begin
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ctl_q.cnt >= SW'(CS_HOLD - 1)) begin
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.valid = 1'b1;
                    ctl_d.data  = sh_word;
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.state   <= ST_IDLE;
            ctl_q.cs_n    <= 1'b1;
            ctl_q.start_n <= 1'b1;
            ctl_q.eoc_s1  <= 1'b1;
            ctl_q.eoc_s2  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o        = (ctl_q.state != ST_IDLE);
    assign data_o        = ctl_q.data;
    assign valid_o       = ctl_q.valid;
    assign err_o         = ctl_q.err;
    assign adc_cs_n_o    = ctl_q.cs_n;
    assign adc_start_n_o = ctl_q.start_n;

endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic start_n,
    input logic cclk,
    input logic sclk,
    input logic eoc_n,
    input logic valid,
    input logic err,
    input logic busy
);
    // R3
    start_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |-> !cs_n);

    // R3
    start_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n != $past(start_n)) |-> $fell(cclk));

    // R5
    sclk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R4
    sclk_after_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !eoc_n);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8
    valid_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    // R9
    err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && valid));

    // R10
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(cs_n));

endmodule

bind adc_serial_host adc_host_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (adc_cs_n_o),
    .start_n (adc_start_n_o),
    .cclk    (adc_cclk_o),
    .sclk    (adc_sclk_o),
    .eoc_n   (adc_eoc_n_i),
    .valid   (valid_o),
    .err     (err_o),
    .busy    (busy_o)
);

// File: tb/tb_adc_serial_host.sv
module tb_adc_serial_host;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int CONV_HALF  = 2;
    localparam int SCLK_HALF  = 2;
    localparam int CS_SETUP   = 5;
    localparam int CS_HOLD    = 3;
    localparam int EOC_TMO    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic busy, valid, err, cs_n, start_n, cclk, sclk;
    logic [WORD_W-1:0] data;
    logic dout = 1'b0;
    logic eoc_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_host #(
        .WORD_W(WORD_W), .CONV_HALF(CONV_HALF), .SCLK_HALF(SCLK_HALF),
        .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD), .EOC_TIMEOUT(EOC_TMO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .busy_o(busy), .data_o(data),
        .valid_o(valid), .err_o(err), .adc_cs_n_o(cs_n), .adc_start_n_o(start_n),
        .adc_cclk_o(cclk), .adc_sclk_o(sclk), .adc_dout_i(dout), .adc_eoc_n_i(eoc_n)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // converter model
    logic [WORD_W-1:0] m_word = '0;
    int  m_len = 1;
    bit  m_resp = 1'b1;
    bit  m_armed = 1'b0;
    int  m_cnt = 0;
    int  m_idx = 0;
    logic m_pstart = 1'b1, m_pcclk = 1'b0, m_psclk = 1'b0;

    always @(negedge clk) begin
        if (cs_n) begin
            eoc_n   = 1'b1;
            dout    = 1'b0;
            m_armed = 1'b0;
        end else begin
            if (!start_n && m_pstart) begin
                m_armed = 1'b1;
                m_cnt   = 0;
            end else if (m_armed && !cclk && m_pcclk) begin
                m_cnt++;
                if (m_cnt == m_len && m_resp) begin
                    eoc_n   = 1'b0;
                    m_idx   = WORD_W - 1;
                    dout    = m_word[WORD_W-1];
                    m_armed = 1'b0;
                end
            end
            if (!eoc_n && !sclk && m_psclk && m_idx > 0) begin
                m_idx--;
                dout = m_word[m_idx];
            end
        end
        m_pstart = start_n;
        m_pcclk  = cclk;
        m_psclk  = sclk;
    end

    // monitor
    logic p_cs = 1'b1, p_start = 1'b1, p_cclk = 1'b0, p_sclk = 1'b0, p_busy = 1'b0;
    int t_cs_fall, t_start_fall, t_start_rise, t_sclk_fall, t_cs_rise;
    int n_rise, n_valid, n_err, n_falls_after;
    bit counting = 1'b0;
    bit sclk_seen = 1'b0, cclk_seen = 1'b0;
    int sclk_run = 0, cclk_run = 0;
    logic [WORD_W-1:0] last_valid_data;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cclk != p_cclk) begin
                // R11 phase length of conversion clock
                if (cclk_seen) check(cclk_run == CONV_HALF, "R11", cclk_run, CONV_HALF);
                cclk_seen = 1'b1;
                cclk_run  = 1;
            end else cclk_run++;
            if (start_n != p_start) begin
                // R3 start edge only with a conversion clock falling edge
                check(!cclk && p_cclk, "R3", {p_cclk, cclk}, 2);
                if (!start_n) t_start_fall = cyc;
                else begin
                    t_start_rise  = cyc;
                    counting      = 1'b1;
                    n_falls_after = 0;
                end
            end else if (counting && !cclk && p_cclk) n_falls_after++;
            if (sclk != p_sclk) begin
                // R5 serial clock phase length
                if (sclk_seen) check(sclk_run == SCLK_HALF, "R5", sclk_run, SCLK_HALF);
                sclk_seen = 1'b1;
                sclk_run  = 1;
                if (sclk) begin
                    n_rise++;
                    check(!eoc_n && !cs_n, "R4", {eoc_n, cs_n}, 0);
                end else t_sclk_fall = cyc;
            end else sclk_run++;
            if (!cs_n && p_cs) begin
                t_cs_fall = cyc;
                check(busy, "R10", busy, 1);
            end
            if (cs_n && !p_cs) begin
                t_cs_rise = cyc;
                counting  = 1'b0;
                sclk_seen = 1'b0;
                check(!busy && p_busy, "R10", {p_busy, busy}, 2);
            end
            if (valid) begin
                n_valid++;
                last_valid_data = data;
                check(cs_n && !p_cs, "R8", {p_cs, cs_n}, 1);
            end
            if (err) n_err++;
        end
        p_cs = cs_n; p_start = start_n; p_cclk = cclk; p_sclk = sclk; p_busy = busy;
    end

    task automatic report_and_finish();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            report_and_finish();
        end
    end

    task automatic run_one(input logic [WORD_W-1:0] w, input int len, input bit resp, input bit poke);
        logic [WORD_W-1:0] old = data;
        int extra_busy = 0;
        m_word = w; m_len = len; m_resp = resp;
        n_rise = 0; n_valid = 0; n_err = 0; n_falls_after = 0;
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        // R2 accepted: busy and chip select
        check(busy && !cs_n, "R2", {busy, cs_n}, 2);
        for (int k = 0; k < 3000 && busy; k++) begin
            @(negedge clk);
            req = poke && (k == 20);
        end
        req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy || !cs_n) extra_busy++;
        end
        if (poke) check(extra_busy == 0, "R2", extra_busy, 0);
        if (resp) begin
            check(n_valid == 1, "R8", n_valid, 1);
            check(n_err == 0, "R9", n_err, 0);
            check(last_valid_data == w, "R6", last_valid_data, w);
            check(data == w, "R8", data, w);
            check(n_rise == WORD_W, "R5", n_rise, WORD_W);
            check(t_start_fall - t_cs_fall >= CS_SETUP, "R3", t_start_fall - t_cs_fall, CS_SETUP);
            check(t_start_rise - t_start_fall == 2*CONV_HALF, "R3", t_start_rise - t_start_fall, 2*CONV_HALF);
            check(t_cs_rise - t_sclk_fall >= CS_HOLD, "R7", t_cs_rise - t_sclk_fall, CS_HOLD);
        end else begin
            check(n_err == 1, "R9", n_err, 1);
            check(n_valid == 0, "R9", n_valid, 0);
            check(n_rise == 0, "R4", n_rise, 0);
            check(n_falls_after == EOC_TMO, "R9", n_falls_after, EOC_TMO);
            check(data == old, "R9", data, old);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 state during reset
        check(cs_n && start_n && !sclk && !busy && !valid && !err && data == '0, "R1",
              {cs_n, start_n, sclk, busy, valid, err}, 6'b110000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n && start_n && !sclk && !busy, "R1", {cs_n, start_n, sclk, busy}, 4'b1100);
        run_one(16'h0000, 2, 1'b1, 1'b0);
        run_one(16'hFFFF, 1, 1'b1, 1'b0);
        run_one(16'h8001, 5, 1'b1, 1'b0);
        run_one(16'h5555, 3, 1'b1, 1'b1);
        run_one(16'h1234, 2, 1'b0, 1'b0);
        run_one(16'hA5C3, 4, 1'b1, 1'b0);
        run_one(16'h0F0F, 1, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic [WORD_W-1:0] w;
            w = WORD_W'($urandom);
            run_one(w, 1 + int'($urandom % 5), 1'b1, ($urandom % 4) == 0);
        end
        report_and_finish();
    end
endmodule